// File: doc/BRIEF.md
# Multi-Ratio Clock Divider and Selector

This block takes one fast source clock and fans it out as nine clocks at three ratios. Index 0 carries the source rate, index 1 carries half of it, and the remaining seven carry a shared rate that software or a strap sets to either one half or one quarter of the source. The source is chosen from three candidates: the oscillator clock in normal use, a skew-test clock that bypasses the oscillator, and an external test clock that overrides both. All slower outputs come from one down-counter clocked by the chosen source, so their rising edges line up with the rising edges of the faster outputs.

Moving from one source to another uses a handshake. The old source is gated off on its own falling edge after a two-flop synchroniser. The new source is gated on in the same way, once the old one is confirmed off. A change of the shared ratio is held back until the counter wraps. An active-low output disable drops all nine drive-enable flags at once. The divider and the source handshake keep running while the flags are low, so the fanout clocks are ready the moment the flags return.

Top module: `ratio_clk_fanout`

## Requirements
- R1: `clk_o[0]` runs at the period of the selected source clock. `clk_o[1]` runs at twice that period.
- R2: The shared outputs `clk_o[8:2]` are identical to one another. With `ratio_sel` high their period is four source periods. With it low their period is two source periods.
- R3: Source priority is `ext_sel` high first (external test clock), then `skw_sel` high (skew-test clock), and otherwise the oscillator clock.
- R4: Every bit of `drv_en` equals the inverse of `oe_n`, without a clock edge in between. The clocks on `clk_o` keep toggling while `oe_n` is high.
- R5: A new `ratio_sel` value is applied only when the counter wraps. Every high and every low pulse on a shared output then lasts exactly one or two source periods. Each shared rising edge falls in the same instant as a rising edge of `clk_o[1]` and of `clk_o[0]`.
- R6: `clk_o[1]` and the shared outputs have a 50% duty cycle. The high time is half the period.
- R7: Switching sources never makes a pulse on `clk_o[0]` shorter than half the period of the faster of the two sources. At most one source is gated through at any time.
- R8: While `rst_n` is low, all nine bits of `clk_o` are low. The first rising edge of `clk_o[0]` after release raises all nine outputs together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock, the normal source |
| clk_ext | input | 1 | External test clock |
| clk_skw | input | 1 | Skew-test clock, bypasses the oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_sel | input | 1 | High selects the external test clock (highest priority) |
| skw_sel | input | 1 | High selects the skew-test clock |
| ratio_sel | input | 1 | Shared-output ratio: high gives quarter rate, low gives half rate |
| oe_n | input | 1 | Active-low output enable for all nine outputs |
| clk_o | output | 9 | Bit 0 source rate, bit 1 half rate, bits 8:2 shared rate |
| drv_en | output | 9 | Per-output drive enable; low means the output is to be high-impedance |

## Verification
Each kind of internal fault shows up at the ports, and does so quickly:

- **Stuck or overlapping gate enables.** The effect appears within a few source periods of a select change. It shows as a missing source period on `clk_o[0]`, or as a pulse shorter than half a source period.
- **Counter in the wrong state.** The shared outputs stop rising together with `clk_o[1]` and `clk_o[0]`, and this is visible on the next shared rising edge.
- **Ratio latched away from the wrap.** The shared output holds a level for three source periods, which shows within one counter cycle of a toggle on `ratio_sel`.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // source index order; the gated-clock vector is packed in this order
   typedef enum logic [1:0] {
      SRC_OSC = 2'd0,
      SRC_SKW = 2'd1,
      SRC_EXT = 2'd2
   } src_e;

   localparam int N_SRC = 3;

   // priority: external test clock, then skew-test clock, then oscillator
   function automatic src_e pick_src(input logic ext, input logic skw);
      if (ext)      return SRC_EXT;
      else if (skw) return SRC_SKW;
      else          return SRC_OSC;
   endfunction
endpackage

// File: rtl/rcf_sync.sv
module rcf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   timeunit 1ns;
   timeprecision 1ps;

   if (STAGES < 2) begin : g_bad_stages
      $error("rcf_sync: STAGES must be 2 or more");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/rcf_src_mux.sv
module rcf_src_mux
   import rcf_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_osc,
   input  logic             clk_skw,
   input  logic             clk_ext,
   input  logic             rst_n,
   input  logic             ext_sel,
   input  logic             skw_sel,
   output logic             clk_sel
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [N_SRC-1:0] clk_src;
   logic [N_SRC-1:0] gate_en;
   logic [N_SRC-1:0] gated;
   src_e             pick;

   assign clk_src = {clk_ext, clk_skw, clk_osc};
   assign pick    = pick_src(ext_sel, skw_sel);

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      logic [N_SRC-1:0] others_on;
      logic             want;
      logic             want_s;
      logic             en_q;

      // a source may ask to open only once every other source has closed
      assign others_on = gate_en & ~(N_SRC'(1) << i);
      assign want      = (int'(pick) == i) && (others_on == '0);

      rcf_sync #(.STAGES(SYNC_STAGES)) u_want_sync (
         .clk   (clk_src[i]),
         .rst_n (rst_n),
         .d     (want),
         .q     (want_s)
      );

      // open and close only while this source is low
      always_ff @(negedge clk_src[i] or negedge rst_n) begin
         if (!rst_n) en_q <= 1'b0;
         else        en_q <= want_s;
      end

      assign gate_en[i] = en_q;
      assign gated[i]   = clk_src[i] & en_q;
   end

   assign clk_sel = |gated;

   always_comb begin
      if (rst_n) begin
         AST_ONE_SOURCE: assert ($onehot0(gate_en)) else $error("two sources gated at once"); // R7
      end
   end
endmodule

// File: rtl/rcf_div.sv
module rcf_div #(
   parameter int DIV_W       = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_div,
   input  logic rst_n,
   input  logic ratio_sel,
   output logic clk_half,
   output logic clk_shr
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [DIV_W-1:0] WRAP_VAL = '0;

   if (DIV_W < 2) begin : g_bad_div
      $error("rcf_div: DIV_W must be 2 or more");
   end

   logic [DIV_W-1:0] cnt;
   logic             ratio_s;
   logic             ratio_q;

   rcf_sync #(.STAGES(SYNC_STAGES)) u_ratio_sync (
      .clk   (clk_div),
      .rst_n (rst_n),
      .d     (ratio_sel),
      .q     (ratio_s)
   );

   // down-counter: each bit rises only when all lower bits rise with it,
   // so slower outputs share rising edges with faster ones
   always_ff @(posedge clk_div or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         ratio_q <= 1'b0;
      end else begin
         cnt <= cnt - DIV_W'(1);
         if (cnt == WRAP_VAL) ratio_q <= ratio_s;
      end
   end

   assign clk_half = cnt[0];
   assign clk_shr  = ratio_q ? cnt[DIV_W-1] : cnt[0];

   AST_RATIO_AT_WRAP: assert property (@(posedge clk_div) disable iff (!rst_n) (cnt != WRAP_VAL) |=> $stable(ratio_q)) else $error("ratio changed away from wrap"); // R5
   AST_SHARED_ALIGN: assert property (@(posedge clk_div) disable iff (!rst_n) $rose(clk_shr) |-> $rose(clk_half)) else $error("shared edge not aligned"); // R5
   AST_QTR_HOLD: assert property (@(posedge clk_div) disable iff (!rst_n) (ratio_q && $rose(clk_shr)) |=> clk_shr) else $error("quarter-rate high too short"); // R6
endmodule

// File: rtl/rcf_drv.sv
module rcf_drv #(
   parameter int N_SHARED = 7,
   localparam int N_OUT   = N_SHARED + 2
) (
   input  logic             clk_full,
   input  logic             clk_half,
   input  logic             clk_shr,
   input  logic             oe_n,
   output logic [N_OUT-1:0] clk_o,
   output logic [N_OUT-1:0] drv_en
);
   timeunit 1ns;
   timeprecision 1ps;

   assign clk_o[0] = clk_full;
   assign clk_o[1] = clk_half;

   for (genvar k = 2; k < N_OUT; k++) begin : g_shr
      assign clk_o[k] = clk_shr;
   end

   // output disable is global and does not touch the clock path
   assign drv_en = {N_OUT{~oe_n}};
endmodule

// File: rtl/ratio_clk_fanout.sv
module ratio_clk_fanout #(
   parameter int N_SHARED    = 7,
   parameter int DIV_W       = 2,
   parameter int SYNC_STAGES = 2,
   localparam int N_OUT      = N_SHARED + 2
) (
   input  logic             clk_osc,
   input  logic             clk_ext,
   input  logic             clk_skw,
   input  logic             rst_n,
   input  logic             ext_sel,
   input  logic             skw_sel,
   input  logic             ratio_sel,
   input  logic             oe_n,
   output logic [N_OUT-1:0] clk_o,
   output logic [N_OUT-1:0] drv_en
);
   timeunit 1ns;
   timeprecision 1ps;

   if (N_SHARED < 1) begin : g_bad_shared
      $error("ratio_clk_fanout: N_SHARED must be 1 or more");
   end

   logic clk_sel;
   logic clk_half;
   logic clk_shr;

   rcf_src_mux #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk_osc (clk_osc),
      .clk_skw (clk_skw),
      .clk_ext (clk_ext),
      .rst_n   (rst_n),
      .ext_sel (ext_sel),
      .skw_sel (skw_sel),
      .clk_sel (clk_sel)
   );

   rcf_div #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_div (
      .clk_div   (clk_sel),
      .rst_n     (rst_n),
      .ratio_sel (ratio_sel),
      .clk_half  (clk_half),
      .clk_shr   (clk_shr)
   );

   rcf_drv #(.N_SHARED(N_SHARED)) u_drv (
      .clk_full (clk_sel),
      .clk_half (clk_half),
      .clk_shr  (clk_shr),
      .oe_n     (oe_n),
      .clk_o    (clk_o),
      .drv_en   (drv_en)
   );
endmodule

// File: tb/ratio_clk_fanout_test.sv
module ratio_clk_fanout_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NSH = 7;
   localparam int NO  = NSH + 2;

   logic clk_osc = 1'b0, clk_ext = 1'b0, clk_skw = 1'b0;
   logic rst_n = 1'b1, ext_sel = 1'b0, skw_sel = 1'b0, ratio_sel = 1'b0, oe_n = 1'b0;
   logic [NO-1:0] clk_o, drv_en;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #4  clk_osc = ~clk_osc;   // 125 MHz
   always #7  clk_skw = ~clk_skw;
   always #10 clk_ext = ~clk_ext;

   ratio_clk_fanout #(.N_SHARED(NSH)) uut (
      .clk_osc   (clk_osc),
      .clk_ext   (clk_ext),
      .clk_skw   (clk_skw),
      .rst_n     (rst_n),
      .ext_sel   (ext_sel),
      .skw_sel   (skw_sel),
      .ratio_sel (ratio_sel),
      .oe_n      (oe_n),
      .clk_o     (clk_o),
      .drv_en    (drv_en)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   // probe of one selected output for period measurement
   int   pidx = 0;
   logic probe;
   assign probe = clk_o[pidx];

   task automatic measure(output longint per, output longint hi);
      time t0, t1, t2;
      @(posedge probe); t0 = $time;
      @(negedge probe); t1 = $time;
      @(posedge probe); t2 = $time;
      per = longint'(t2 - t0);
      hi  = longint'(t1 - t0);
   endtask

   // monitors
   bit  mon_glitch = 1'b0, mon_align = 1'b0, mon_width = 1'b0;
   int  n_glitch = 0, n_misalign = 0, n_badw = 0;
   time t_full_edge = 0, t_full_rise = 0, t_half_rise = 0, t_shr_edge = 0;

   always @(clk_o[0]) begin
      if (mon_glitch && ($time - t_full_edge) < 4) n_glitch++;
      t_full_edge = $time;
   end
   always @(posedge clk_o[0]) t_full_rise = $time;
   always @(posedge clk_o[1]) t_half_rise = $time;
   always @(posedge clk_o[2]) begin
      time ts;
      if (mon_align) begin
         ts = $time;
         #1;
         if (t_half_rise != ts || t_full_rise != ts) n_misalign++;
      end
   end
   always @(clk_o[2]) begin
      time w;
      w = $time - t_shr_edge;
      if (mon_width && w != 8 && w != 16) n_badw++;
      t_shr_edge = $time;
   end

   // {ext_sel, skw_sel, ratio_sel, oe_n, full period, half period, shared period}
   localparam int ROWS [8][7] = '{
      '{0, 0, 1, 0,  8, 16, 32},
      '{0, 0, 0, 0,  8, 16, 16},
      '{0, 1, 1, 0, 14, 28, 56},
      '{0, 1, 0, 0, 14, 28, 28},
      '{1, 0, 1, 0, 20, 40, 80},
      '{1, 1, 0, 0, 20, 40, 40},
      '{0, 0, 1, 1,  8, 16, 32},
      '{1, 1, 1, 1, 20, 40, 80}
   };

   initial begin
      longint per, hi;
      logic [NO-1:0] exp_en;
      bit rst_ok;

      // reset state
      #1 rst_n = 1'b0;
      rst_ok = 1'b1;
      #20 rst_ok &= (clk_o == '0);
      #30 rst_ok &= (clk_o == '0);
      #40 rst_ok &= (clk_o == '0);
      chk(rst_ok, "R8", "outputs low in reset", longint'(clk_o), 0);
      chk(drv_en == '1, "R4", "enables during reset with oe_n low", longint'(drv_en), 511);
      #9.5 rst_n = 1'b1;
      @(posedge clk_o[0]); #1;
      chk(clk_o == '1, "R8", "first edge raises all outputs", longint'(clk_o), 511);

      // table walk over sources, ratios and enables
      mon_glitch = 1'b1;
      mon_align  = 1'b1;
      for (int r = 0; r < 8; r++) begin
         ext_sel   = ROWS[r][0][0];
         skw_sel   = ROWS[r][1][0];
         ratio_sel = ROWS[r][2][0];
         oe_n      = ROWS[r][3][0];
         #600.5;
         exp_en = ROWS[r][3] != 0 ? '0 : '1;
         chk(drv_en == exp_en, "R4", $sformatf("row %0d drive enables", r),
             longint'(drv_en), longint'(exp_en));
         pidx = 0; #1;
         measure(per, hi);
         chk(per == ROWS[r][4], "R1 R3", $sformatf("row %0d full period", r), per, ROWS[r][4]);
         pidx = 1; #1;
         measure(per, hi);
         chk(per == ROWS[r][5], "R1", $sformatf("row %0d half period", r), per, ROWS[r][5]);
         chk(hi == ROWS[r][5] / 2, "R6", $sformatf("row %0d half high time", r), hi, ROWS[r][5] / 2);
         pidx = 2; #1;
         measure(per, hi);
         chk(per == ROWS[r][6], "R2", $sformatf("row %0d shared period", r), per, ROWS[r][6]);
         chk(hi == ROWS[r][6] / 2, "R6", $sformatf("row %0d shared high time", r), hi, ROWS[r][6] / 2);
         #1;
         chk(clk_o[NO-1:2] == '0 || clk_o[NO-1:2] == '1, "R2",
             $sformatf("row %0d shared outputs equal", r), longint'(clk_o[NO-1:2]), 127);
      end
      mon_glitch = 1'b0;
      mon_align  = 1'b0;
      #2;
      chk(n_glitch == 0, "R7", "short pulses on full output while switching", n_glitch, 0);
      chk(n_misalign == 0, "R5", "misaligned shared edges in table", n_misalign, 0);

      // ratio toggled at many phases on the oscillator source
      ext_sel = 1'b0; skw_sel = 1'b0; oe_n = 1'b0; ratio_sel = 1'b1;
      #600.5;
      n_misalign = 0;
      mon_width  = 1'b1;
      mon_align  = 1'b1;
      for (int k = 0; k < 16; k++) begin
         #(13 + k * 3) ratio_sel = ~ratio_sel;
      end
      #200;
      mon_width = 1'b0;
      mon_align = 1'b0;
      #2;
      chk(n_badw == 0, "R5", "shared pulse widths across ratio toggles", n_badw, 0);
      chk(n_misalign == 0, "R5", "shared edge alignment across ratio toggles", n_misalign, 0);

      // output disable leaves clocks running
      ratio_sel = 1'b1;
      #300.5;
      oe_n = 1'b1; #1;
      chk(drv_en == '0, "R4", "enables drop at once", longint'(drv_en), 0);
      pidx = NO - 1; #1;
      measure(per, hi);
      chk(per == 32, "R4", "shared clock runs while disabled", per, 32);
      #0.5 oe_n = 1'b0; #1;
      chk(drv_en == '1, "R4", "enables return at once", longint'(drv_en), 511);

      // reset in the middle of skew-test operation
      ratio_sel = 1'b0; skw_sel = 1'b1;
      #400.5 rst_n = 1'b0;
      #1 chk(clk_o == '0, "R8", "outputs cleared by reset", longint'(clk_o), 0);
      #50 chk(clk_o == '0, "R8", "outputs held low in reset", longint'(clk_o), 0);
      rst_n = 1'b1;
      @(posedge clk_o[0]); #1;
      chk(clk_o == '1, "R8", "first edge after reset raises all", longint'(clk_o), 511);
      pidx = 0; #1;
      measure(per, hi);
      chk(per == 14, "R3", "skew-test source after reset", per, 14);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got 0 expected 1 completed run");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule